// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block tracks the coherence state of a few cache lines in one cache that shares a broadcast bus with peer caches. A processor-side port issues single-word reads and writes, one word per line. The controller answers hits at once. It goes to the bus for misses, for upgrades of shared lines and for write-back of dirty victims. It also watches every broadcast from the peers and moves its own line states to match.

Each line is Invalid, Shared, Exclusive or Modified. No state stands for a line that is both dirty and shared. A peer read that hits a Modified line is served straight from this cache, and after it both copies are Shared. Local writes to Shared lines must first invalidate the other copies. Writes to Exclusive lines need no bus traffic. Bus arbitration and main memory sit outside the block. Memory answers every read that no cache supplies.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. No bus request, no processor acknowledge and no snoop response is raised until a request arrives.
- R2: A processor read that hits a valid line raises cpu_ack_o in the same cycle, returns the stored word and starts no bus transaction.
- R3: A read miss requests the bus with op code 0 (read) on the missed line address. While ungranted, the op and address stay steady. The line fills Exclusive if bus_shared_i is low at completion and Shared if it is high.
- R4: A write to an Exclusive line completes with no bus transaction and leaves the line Modified.
- R5: A write to a Shared line first issues op code 2 (upgrade) on that address. After completion the line is Modified and holds the written word.
- R6: A write miss issues op code 1 (read for ownership). The line fills directly in Modified and holds the written word.
- R7: A snooped read (op 0) that hits raises snp_shared_o and leaves the line Shared. If the line was Modified, snp_supply_o is also raised and snp_data_o carries the line's word.
- R8: A snooped read-for-ownership (op 1) or upgrade (op 2) that hits leaves the line Invalid. A Modified line supplies its word on op 1. A later local access to that line misses.
- R9: A snooped write-back (op 3), a snoop that misses, and an idle snoop port raise neither snp_shared_o nor snp_supply_o, and change no line state.
- R10: A miss whose victim is Modified first issues op code 3 (write-back) carrying the victim's address and word. The read for the new line follows. Victims are taken from the lowest free slot, else round-robin.
- R11: A miss whose victim is clean drops it without any write-back.
- R12: A snoop that arrives while a local bus request is still ungranted withdraws that request for the cycle. The local access is then re-evaluated against the updated state, so an upgrade whose line was invalidated becomes a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request, held until acknowledged |
| cpu_we_i | input | 1 | Request is a write |
| cpu_addr_i | input | ADDR_W | Line address of the request |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_ack_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read word, valid with cpu_ack_o |
| bus_req_o | output | 1 | Bus transaction wanted |
| bus_op_o | output | 2 | 0 read, 1 read for ownership, 2 upgrade, 3 write-back |
| bus_addr_o | output | ADDR_W | Line address of the transaction |
| bus_wdata_o | output | DATA_W | Write-back word |
| bus_gnt_i | input | 1 | Bus granted to this cache |
| bus_done_i | input | 1 | Own transaction completes |
| bus_shared_i | input | 1 | A peer holds the line, sampled with bus_done_i |
| bus_rdata_i | input | DATA_W | Fill word, sampled with bus_done_i |
| snp_valid_i | input | 1 | Peer broadcast present |
| snp_op_i | input | 2 | Peer broadcast op, same coding as bus_op_o |
| snp_addr_i | input | ADDR_W | Peer broadcast line address |
| snp_shared_o | output | 1 | This cache holds the snooped line (read snoops) |
| snp_supply_o | output | 1 | This cache supplies the line's word |
| snp_data_o | output | DATA_W | Supplied word |

## Verification
A wrong line state in this block shows at the ports within a handful of cycles. An Exclusive line held as Shared produces an unexpected upgrade on the next write. A line wrongly left valid after an invalidating snoop gives a hit instead of a bus read. A Modified line recorded as clean fails to raise the supply flag, or skips the write-back on eviction. The snoop outputs respond in the same cycle as the broadcast, so one snoop probe after each step reveals the state just reached. A write beforehand makes the probe expose the stored word as well.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_RDX = 2'd1, OP_UPG = 2'd2, OP_WB = 2'd3} bus_op_e;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_REQ = 2'd1, F_WAIT = 2'd2} fsm_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store import mesi_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [ADDR_W-1:0]                  cpu_addr_i,
  input  logic [ADDR_W-1:0]                  snp_addr_i,
  input  logic                               snp_upd_i,
  input  logic [IDX_W-1:0]                   snp_idx_i,
  input  logic [1:0]                         snp_st_i,
  input  logic                               wr_en_i,
  input  logic [IDX_W-1:0]                   wr_idx_i,
  input  logic [1:0]                         wr_st_i,
  input  logic                               wr_tag_en_i,
  input  logic [ADDR_W-1:0]                  wr_tag_i,
  input  logic                               wr_data_en_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  output logic                               cpu_hit_o,
  output logic [IDX_W-1:0]                   cpu_idx_o,
  output logic                               snp_hit_o,
  output logic [IDX_W-1:0]                   snp_idx_o,
  output logic [NUM_LINES-1:0][1:0]          st_o,
  output logic [NUM_LINES-1:0][ADDR_W-1:0]   tag_o,
  output logic [NUM_LINES-1:0][DATA_W-1:0]   data_o
);
  logic [NUM_LINES-1:0] cpu_match, snp_match;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [1:0]        st_r;
    logic [ADDR_W-1:0] tag_r;
    logic [DATA_W-1:0] data_r;
    logic              sel_wr, sel_snp;

    assign sel_wr  = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign sel_snp = snp_upd_i && (snp_idx_i == IDX_W'(g));

    // local writes win over a snoop on the same slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_r   <= ST_I;
        tag_r  <= '0;
        data_r <= '0;
      end else begin
        if (sel_wr) begin
          st_r <= wr_st_i;
          if (wr_tag_en_i)  tag_r  <= wr_tag_i;
          if (wr_data_en_i) data_r <= wr_data_i;
        end else if (sel_snp) begin
          st_r <= snp_st_i;
        end
      end
    end

    assign st_o[g]      = st_r;
    assign tag_o[g]     = tag_r;
    assign data_o[g]    = data_r;
    assign cpu_match[g] = (st_r != ST_I) && (tag_r == cpu_addr_i);
    assign snp_match[g] = (st_r != ST_I) && (tag_r == snp_addr_i);
  end

  assign cpu_hit_o = |cpu_match;
  assign snp_hit_o = |snp_match;

  always_comb begin
    cpu_idx_o = '0;
    snp_idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cpu_match[i]) cpu_idx_o = IDX_W'(i);
      if (snp_match[i]) snp_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit import mesi_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic              snp_hit_i,
  input  logic [1:0]        line_st_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] data_o,
  output logic              upd_o,
  output logic [1:0]        new_st_o
);
  always_comb begin
    shared_o = 1'b0;
    supply_o = 1'b0;
    upd_o    = 1'b0;
    new_st_o = ST_I;
    if (snp_valid_i && snp_hit_i) begin
      case (snp_op_i)
        OP_RD: begin
          shared_o = 1'b1;
          supply_o = (line_st_i == ST_M);
          upd_o    = 1'b1;
          new_st_o = ST_S;
        end
        OP_RDX: begin
          supply_o = (line_st_i == ST_M);
          upd_o    = 1'b1;
          new_st_o = ST_I;
        end
        OP_UPG: begin
          upd_o    = 1'b1;
          new_st_o = ST_I;
        end
        default: ;
      endcase
    end
  end

  assign data_o = supply_o ? line_data_i : '0;
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm import mesi_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               cpu_req_i,
  input  logic                               cpu_we_i,
  input  logic [ADDR_W-1:0]                  cpu_addr_i,
  input  logic [DATA_W-1:0]                  cpu_wdata_i,
  input  logic                               cpu_hit_i,
  input  logic [IDX_W-1:0]                   cpu_idx_i,
  input  logic [NUM_LINES-1:0][1:0]          st_i,
  input  logic [NUM_LINES-1:0][ADDR_W-1:0]   tag_i,
  input  logic [NUM_LINES-1:0][DATA_W-1:0]   data_i,
  input  logic                               snp_valid_i,
  input  logic                               bus_gnt_i,
  input  logic                               bus_done_i,
  input  logic                               bus_shared_i,
  input  logic [DATA_W-1:0]                  bus_rdata_i,
  output logic                               cpu_ack_o,
  output logic [DATA_W-1:0]                  cpu_rdata_o,
  output logic                               bus_req_o,
  output logic [1:0]                         bus_op_o,
  output logic [ADDR_W-1:0]                  bus_addr_o,
  output logic [DATA_W-1:0]                  bus_wdata_o,
  output logic                               wr_en_o,
  output logic [IDX_W-1:0]                   wr_idx_o,
  output logic [1:0]                         wr_st_o,
  output logic                               wr_tag_en_o,
  output logic [ADDR_W-1:0]                  wr_tag_o,
  output logic                               wr_data_en_o,
  output logic [DATA_W-1:0]                  wr_data_o
);
  fsm_e              state_q, state_d;
  logic [1:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  rr_q, victim, free_idx;
  logic              has_free, fill_done;
  logic [1:0]        hit_st;

  // lowest free slot first, else round-robin
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (st_i[i] == ST_I) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    victim = has_free ? free_idx : rr_q;
  end

  always_comb begin
    state_d      = state_q;
    op_d         = op_q;
    addr_d       = addr_q;
    idx_d        = idx_q;
    cpu_ack_o    = 1'b0;
    cpu_rdata_o  = '0;
    bus_req_o    = 1'b0;
    wr_en_o      = 1'b0;
    wr_idx_o     = idx_q;
    wr_st_o      = ST_I;
    wr_tag_en_o  = 1'b0;
    wr_data_en_o = 1'b0;
    wr_data_o    = bus_rdata_i;
    hit_st       = st_i[cpu_idx_i];
    case (state_q)
      F_IDLE: begin
        // a snoop this cycle stalls the local side
        if (cpu_req_i && !snp_valid_i) begin
          if (cpu_hit_i) begin
            if (!cpu_we_i) begin
              cpu_ack_o   = 1'b1;
              cpu_rdata_o = data_i[cpu_idx_i];
            end else if (hit_st == ST_S) begin
              op_d    = OP_UPG;
              addr_d  = cpu_addr_i;
              idx_d   = cpu_idx_i;
              state_d = F_REQ;
            end else begin
              cpu_ack_o    = 1'b1;
              wr_en_o      = 1'b1;
              wr_idx_o     = cpu_idx_i;
              wr_st_o      = ST_M;
              wr_data_en_o = 1'b1;
              wr_data_o    = cpu_wdata_i;
            end
          end else begin
            idx_d   = victim;
            state_d = F_REQ;
            if (st_i[victim] == ST_M) begin
              op_d   = OP_WB;
              addr_d = tag_i[victim];
            end else begin
              op_d   = cpu_we_i ? OP_RDX : OP_RD;
              addr_d = cpu_addr_i;
            end
          end
        end
      end
      F_REQ: begin
        bus_req_o = !snp_valid_i;
        if (snp_valid_i)    state_d = F_IDLE;
        else if (bus_gnt_i) state_d = F_WAIT;
      end
      F_WAIT: begin
        if (bus_done_i) begin
          state_d = F_IDLE;
          wr_en_o = 1'b1;
          case (op_q)
            OP_WB:  wr_st_o = ST_I;
            OP_UPG: wr_st_o = ST_M;
            OP_RDX: begin
              wr_st_o      = ST_M;
              wr_tag_en_o  = 1'b1;
              wr_data_en_o = 1'b1;
            end
            default: begin
              wr_st_o      = bus_shared_i ? ST_S : ST_E;
              wr_tag_en_o  = 1'b1;
              wr_data_en_o = 1'b1;
            end
          endcase
        end
      end
      default: state_d = F_IDLE;
    endcase
  end

  assign fill_done   = (state_q == F_WAIT) && bus_done_i && (op_q == OP_RD || op_q == OP_RDX);
  assign wr_tag_o    = addr_q;
  assign bus_op_o    = op_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = (op_q == OP_WB) ? data_i[idx_q] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= F_IDLE;
      op_q    <= OP_RD;
      addr_q  <= '0;
      idx_q   <= '0;
      rr_q    <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      idx_q   <= idx_d;
      if (fill_done) rr_q <= (rr_q == IDX_W'(NUM_LINES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl import mesi_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_gnt_i,
  input  logic              bus_done_i,
  input  logic              bus_shared_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic                             cpu_hit, snp_hit, snp_upd;
  logic [IDX_W-1:0]                 cpu_idx, snp_idx, wr_idx;
  logic [1:0]                       snp_st, wr_st;
  logic                             wr_en, wr_tag_en, wr_data_en;
  logic [ADDR_W-1:0]                wr_tag;
  logic [DATA_W-1:0]                wr_data;
  logic [NUM_LINES-1:0][1:0]        st;
  logic [NUM_LINES-1:0][ADDR_W-1:0] tag;
  logic [NUM_LINES-1:0][DATA_W-1:0] data;

  mesi_line_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
  ) u_store (
    .clk_i, .rst_ni,
    .cpu_addr_i, .snp_addr_i,
    .snp_upd_i(snp_upd), .snp_idx_i(snp_idx), .snp_st_i(snp_st),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_st_i(wr_st),
    .wr_tag_en_i(wr_tag_en), .wr_tag_i(wr_tag),
    .wr_data_en_i(wr_data_en), .wr_data_i(wr_data),
    .cpu_hit_o(cpu_hit), .cpu_idx_o(cpu_idx),
    .snp_hit_o(snp_hit), .snp_idx_o(snp_idx),
    .st_o(st), .tag_o(tag), .data_o(data)
  );

  mesi_snoop_unit #(.DATA_W(DATA_W)) u_snoop (
    .snp_valid_i, .snp_op_i,
    .snp_hit_i(snp_hit),
    .line_st_i(st[snp_idx]),
    .line_data_i(data[snp_idx]),
    .shared_o(snp_shared_o), .supply_o(snp_supply_o), .data_o(snp_data_o),
    .upd_o(snp_upd), .new_st_o(snp_st)
  );

  mesi_req_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_hit_i(cpu_hit), .cpu_idx_i(cpu_idx),
    .st_i(st), .tag_i(tag), .data_i(data),
    .snp_valid_i,
    .bus_gnt_i, .bus_done_i, .bus_shared_i, .bus_rdata_i,
    .cpu_ack_o, .cpu_rdata_o,
    .bus_req_o, .bus_op_o, .bus_addr_o, .bus_wdata_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_st_o(wr_st),
    .wr_tag_en_o(wr_tag_en), .wr_tag_o(wr_tag),
    .wr_data_en_o(wr_data_en), .wr_data_o(wr_data)
  );
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk import mesi_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_ack_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [1:0]        bus_op_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              snp_valid_i,
  input logic [1:0]        snp_op_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              snp_shared_o,
  input logic              snp_supply_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !bus_req_o && !cpu_ack_o);

  // R2
  ack_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> cpu_req_i && !bus_req_o);

  // R3
  req_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> !bus_req_o || ($stable(bus_op_o) && $stable(bus_addr_o)));

  // R7
  supply_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> snp_valid_i && (snp_op_i == OP_RD || snp_op_i == OP_RDX));

  // R7
  supply_shared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o && snp_op_i == OP_RD |-> snp_shared_o);

  // R8
  rdx_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_op_i == OP_RDX && snp_supply_o |=>
      !(snp_valid_i && snp_addr_i == $past(snp_addr_i)) || (!snp_shared_o && !snp_supply_o));

  // R9
  wb_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_op_i == OP_WB |-> !snp_shared_o && !snp_supply_o);

  // R9
  idle_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> !snp_shared_o && !snp_supply_o);

  // R12
  snoop_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !snp_valid_i);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_ack_o(cpu_ack_o),
  .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_op_o(bus_op_o),
  .bus_addr_o(bus_addr_o), .snp_valid_i(snp_valid_i), .snp_op_i(snp_op_i),
  .snp_addr_i(snp_addr_i), .snp_shared_o(snp_shared_o), .snp_supply_o(snp_supply_o)
);

// File: tb/mesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NL = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic          cpu_ack_o;
  logic [DW-1:0] cpu_rdata_o;
  logic          bus_req_o;
  logic [1:0]    bus_op_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic          bus_gnt_i = 1'b0, bus_done_i = 1'b0, bus_shared_i = 1'b0;
  logic [DW-1:0] bus_rdata_i = '0;
  logic          snp_valid_i = 1'b0;
  logic [1:0]    snp_op_i = '0;
  logic [AW-1:0] snp_addr_i = '0;
  logic          snp_shared_o, snp_supply_o;
  logic [DW-1:0] snp_data_o;

  int n_checks = 0, n_fail = 0, n_ops = 0;
  logic          peer_shared = 1'b0, hold_gnt = 1'b0, gnt_d = 1'b0;
  logic [1:0]    last_op = '0, prev_op = '0;
  logic [AW-1:0] last_addr = '0, prev_addr = '0;
  logic [DW-1:0] last_wdata = '0, prev_wdata = '0;

  always #5 clk_i = ~clk_i;

  mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_LINES(NL)) u_dut (.*);

  function automatic logic [DW-1:0] mem_fn(logic [AW-1:0] a);
    return {8'hC3, a, ~a, a ^ 8'h5A};
  endfunction

  // memory and arbiter model: grant, then complete one cycle later
  initial begin
    forever begin
      @(negedge clk_i);
      bus_done_i = 1'b0;
      if (gnt_d) begin
        bus_gnt_i    = 1'b0;
        bus_done_i   = 1'b1;
        bus_rdata_i  = mem_fn(bus_addr_o);
        bus_shared_i = peer_shared;
        gnt_d        = 1'b0;
      end else if (bus_req_o && !hold_gnt) begin
        bus_gnt_i  = 1'b1;
        gnt_d      = 1'b1;
        prev_op    = last_op;    prev_addr = last_addr;    prev_wdata = last_wdata;
        last_op    = bus_op_o;   last_addr = bus_addr_o;   last_wdata = bus_wdata_o;
        n_ops++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; cpu_req_i = 1'b0; snp_valid_i = 1'b0;
    hold_gnt = 1'b0; peer_shared = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic cpu_access(input logic we, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    int t;
    @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = wd;
    #1;
    t = 0;
    while (!cpu_ack_o && t < 60) begin
      @(negedge clk_i); #1; t++;
    end
    check("cpu ack arrives", 64'(cpu_ack_o), 64'd1);
    rd = cpu_rdata_o;
    @(negedge clk_i);
    cpu_req_i = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a,
                       output logic sh, output logic sp, output logic [DW-1:0] d);
    @(negedge clk_i);
    snp_valid_i = 1'b1; snp_op_i = op; snp_addr_i = a;
    #1;
    sh = snp_shared_o; sp = snp_supply_o; d = snp_data_o;
    @(negedge clk_i);
    snp_valid_i = 1'b0;
  endtask

  logic [DW-1:0] rd, sd;
  logic sh, sp;
  int n0;

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 ack idle", 64'(cpu_ack_o), 64'd0);
    check("R1 bus_req idle", 64'(bus_req_o), 64'd0);
    snoop(2'd0, 8'h10, sh, sp, sd);
    check("R1 snoop shared after reset", 64'(sh), 64'd0);
    check("R1 snoop supply after reset", 64'(sp), 64'd0);
  endtask

  task automatic t_read_excl();
    do_reset();
    n0 = n_ops;
    cpu_access(1'b0, 8'h10, '0, rd);
    check("R3 read miss data", 64'(rd), 64'(mem_fn(8'h10)));
    check("R3 read miss one op", 64'(n_ops), 64'(n0 + 1));
    check("R3 op code read", 64'(last_op), 64'd0);
    check("R3 op address", 64'(last_addr), 64'h10);
    cpu_access(1'b0, 8'h10, '0, rd);
    check("R2 hit data", 64'(rd), 64'(mem_fn(8'h10)));
    check("R2 hit no bus op", 64'(n_ops), 64'(n0 + 1));
    cpu_access(1'b1, 8'h10, 32'hDEAD0001, rd);
    check("R4 exclusive write silent", 64'(n_ops), 64'(n0 + 1));
    snoop(2'd0, 8'h10, sh, sp, sd);
    check("R7 modified supplies", 64'(sp), 64'd1);
    check("R7 supplied word", 64'(sd), 64'h0DEAD0001);
    check("R7 shared raised", 64'(sh), 64'd1);
    snoop(2'd0, 8'h10, sh, sp, sd);
    check("R7 now shared, no supply", 64'(sp), 64'd0);
    check("R7 now shared, shared raised", 64'(sh), 64'd1);
    cpu_access(1'b0, 8'h10, '0, rd);
    check("R7 local copy kept", 64'(rd), 64'h0DEAD0001);
  endtask

  task automatic t_read_shared();
    do_reset();
    peer_shared = 1'b1;
    cpu_access(1'b0, 8'h20, '0, rd);
    n0 = n_ops;
    cpu_access(1'b1, 8'h20, 32'h12345678, rd);
    check("R3 shared fill needs upgrade", 64'(n_ops), 64'(n0 + 1));
    check("R5 op code upgrade", 64'(last_op), 64'd2);
    check("R5 upgrade address", 64'(last_addr), 64'h20);
    snoop(2'd0, 8'h20, sh, sp, sd);
    check("R5 modified after upgrade", 64'(sp), 64'd1);
    check("R5 written word", 64'(sd), 64'h12345678);
    // line now Shared
    snoop(2'd3, 8'h20, sh, sp, sd);
    check("R9 write-back snoop shared", 64'(sh), 64'd0);
    check("R9 write-back snoop supply", 64'(sp), 64'd0);
    snoop(2'd0, 8'h77, sh, sp, sd);
    check("R9 miss snoop shared", 64'(sh), 64'd0);
    snoop(2'd0, 8'h20, sh, sp, sd);
    check("R9 state unchanged", 64'(sh), 64'd1);
  endtask

  task automatic t_write_miss();
    do_reset();
    n0 = n_ops;
    cpu_access(1'b1, 8'h30, 32'hCAFE0030, rd);
    check("R6 one op", 64'(n_ops), 64'(n0 + 1));
    check("R6 op code rfo", 64'(last_op), 64'd1);
    snoop(2'd1, 8'h30, sh, sp, sd);
    check("R6 fills modified", 64'(sp), 64'd1);
    check("R6 holds write word", 64'(sd), 64'h0CAFE0030);
    check("R8 rfo snoop no shared", 64'(sh), 64'd0);
    n0 = n_ops;
    cpu_access(1'b0, 8'h30, '0, rd);
    check("R8 invalid after rfo snoop", 64'(n_ops), 64'(n0 + 1));
    check("R8 refetched word", 64'(rd), 64'(mem_fn(8'h30)));
  endtask

  task automatic t_snoop_upg();
    do_reset();
    peer_shared = 1'b1;
    cpu_access(1'b0, 8'h40, '0, rd);
    snoop(2'd2, 8'h40, sh, sp, sd);
    check("R8 upgrade snoop quiet", 64'({sh, sp}), 64'd0);
    n0 = n_ops;
    cpu_access(1'b0, 8'h40, '0, rd);
    check("R8 invalid after upgrade snoop", 64'(n_ops), 64'(n0 + 1));
  endtask

  task automatic t_dirty_evict();
    do_reset();
    for (int i = 0; i < NL; i++) cpu_access(1'b1, AW'(8'h50 + i), 32'hB0000000 + i, rd);
    n0 = n_ops;
    cpu_access(1'b0, 8'h60, '0, rd);
    check("R10 two ops", 64'(n_ops), 64'(n0 + 2));
    check("R10 first op write-back", 64'(prev_op), 64'd3);
    check("R10 victim address", 64'(prev_addr), 64'h50);
    check("R10 victim word", 64'(prev_wdata), 64'hB0000000);
    check("R10 then read", 64'(last_op), 64'd0);
    check("R10 new line data", 64'(rd), 64'(mem_fn(8'h60)));
    snoop(2'd0, 8'h50, sh, sp, sd);
    check("R10 victim gone", 64'({sh, sp}), 64'd0);
  endtask

  task automatic t_clean_evict();
    do_reset();
    for (int i = 0; i < NL; i++) cpu_access(1'b0, AW'(8'h70 + i), '0, rd);
    n0 = n_ops;
    cpu_access(1'b0, 8'h74, '0, rd);
    check("R11 no write-back", 64'(n_ops), 64'(n0 + 1));
    check("R11 read only", 64'(last_op), 64'd0);
    snoop(2'd0, 8'h70, sh, sp, sd);
    check("R11 clean victim dropped", 64'(sh), 64'd0);
  endtask

  task automatic t_abort();
    do_reset();
    peer_shared = 1'b1;
    cpu_access(1'b0, 8'h80, '0, rd);
    hold_gnt = 1'b1;
    n0 = n_ops;
    fork
      cpu_access(1'b1, 8'h80, 32'hABCD0080, rd);
      begin
        repeat (3) @(negedge clk_i);
        #1;
        check("R12 upgrade pending", 64'({bus_req_o, bus_op_o}), 64'b110);
        snoop(2'd2, 8'h80, sh, sp, sd);
        hold_gnt = 1'b0;
      end
    join
    check("R12 one granted op", 64'(n_ops), 64'(n0 + 1));
    check("R12 retried as rfo", 64'(last_op), 64'd1);
    snoop(2'd0, 8'h80, sh, sp, sd);
    check("R12 final word", 64'(sd), 64'h0ABCD0080);
    check("R12 final supply", 64'(sp), 64'd1);
  endtask

  initial begin
    t_reset();
    t_read_excl();
    t_read_shared();
    t_write_miss();
    t_snoop_upg();
    t_dirty_evict();
    t_clean_evict();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule